// File: doc/BRIEF.md
# Seven-Channel Open-Drain Pulse-Width Generator

This block produces seven pulse-width outputs from one shared timebase. A prescaler divides the system clock into PWM ticks, and an 8-bit cycle counter advances once per tick, so every output repeats after 256 ticks. Each channel has an 8-bit duty value. The duty value sets how long that channel pulls its pin low at the start of each cycle. For the rest of the cycle the pin is released.

The pins are open-drain. A channel can only pull its pin low, and a released pin reads high only through a pull-up. The block gives one drive-low enable per channel. It also gives one internal pull-up enable per channel, taken from two pull-up control registers.

A CPU writes all registers through a write-only port with an address, a data byte and a strobe. A duty write first lands in a shadow register. It reaches the comparator only when the cycle counter wraps, so a cycle never shows a mix of old and new values.

Top module: `pwm_od_multi`

## Requirements
- R1: A synchronous active-high `rst` clears the prescaler, the cycle counter, all duty values and all pull-up enables. While `rst` is held and after it is released, every `drv_low_o` bit is 0 until a nonzero duty value takes effect.
- R2: A PWM tick occurs once every `PRESCALE` clocks (16 by default). One output cycle lasts 256 ticks, and each cycle starts with the counter at 0.
- R3: A channel whose active duty value is 0x00 never drives its pin low.
- R4: A channel whose active duty value D is in 0x01..0xFF drives low from the first tick of each cycle for D+1 ticks, then releases the pin until the cycle ends.
- R5: The step from 0x00 to 0x01 adds 2 ticks of low time, and every later step adds 1 tick. The value 0x01 gives 2 ticks and 0xFF holds the pin low for the whole 256-tick cycle.
- R6: A write to a duty register (address 0..6 = channel 0..6) does not change the current cycle. The new value takes effect at the next cycle start.
- R7: A write to address 7 loads the pull-up enables of channels 0, 1 and 2 from data bits 5, 6 and 7. A 1 enables the pull-up. Bits 0..4 have no effect.
- R8: A write to address 8 loads the pull-up enables of channels 3, 4, 5 and 6 from data bits 0, 1, 2 and 3. Bits 4..7 have no effect.
- R9: Writes with `wr_en` low, and writes to addresses 9..15, change neither any duty value nor any pull-up enable. Pull-up writes do not change duty values.
- R10: Each channel follows only its own duty value. All channels start their low phase on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address: 0..6 duty, 7 and 8 pull-up |
| wr_data | input | 8 | Register write data |
| drv_low_o | output | 7 | Per-channel open-drain pull-down enable |
| pullup_en_o | output | 7 | Per-channel internal pull-up enable |

## Verification
The bench builds the block with `PRESCALE` = 2 and keeps 7 channels. This shortens a full output cycle to 512 clocks. That is short enough to measure complete low times for many duty patterns, including the 0x00, 0x01, 0xFE and 0xFF extremes. It is also short enough to watch a shadow write wait across a cycle boundary, and to place the high-to-low edge of a mid-range duty value to the exact clock. With these values, whole-cycle low counts can be compared directly against D+1 ticks times the prescale.

// File: rtl/pwm_od_pkg.sv
package pwm_od_pkg;

  localparam int unsigned DATA_W  = 8;
  localparam int unsigned CNT_MAX = (1 << DATA_W) - 1;

  // Low phase covers counter values 0..duty, i.e. duty+1 ticks; duty 0 never low.
  function automatic logic in_low_phase(input logic [DATA_W-1:0] duty,
                                        input logic [DATA_W-1:0] cnt);
    return (duty != '0) && (cnt <= duty);
  endfunction

endpackage

// File: rtl/pwm_od_timebase.sv
module pwm_od_timebase
  import pwm_od_pkg::*;
#(
  parameter int unsigned PRESCALE = 16
) (
  input  logic              clk,
  input  logic              rst,
  output logic              tick_o,
  output logic              wrap_o,
  output logic [DATA_W-1:0] cnt_o
);

  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [PRE_W-1:0]  pre_q;
  logic [DATA_W-1:0] cnt_q;

  assign tick_o = (pre_q == PRE_W'(PRESCALE - 1));
  assign wrap_o = tick_o && (cnt_q == DATA_W'(CNT_MAX));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
    end else if (tick_o) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/pwm_od_regs.sv
module pwm_od_regs
  import pwm_od_pkg::*;
#(
  parameter int unsigned NUM_CH  = 7,
  parameter int unsigned PU_SPLIT = 3,
  parameter int unsigned PU_A_LSB = 5,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [NUM_CH-1:0][DATA_W-1:0] shadow_o,
  output logic [NUM_CH-1:0]             pullup_o
);

  localparam logic [ADDR_W-1:0] PU_A_ADDR = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] PU_B_ADDR = ADDR_W'(NUM_CH + 1);

  logic pu_a_wr;
  logic pu_b_wr;

  assign pu_a_wr = wr_en && (wr_addr == PU_A_ADDR);
  assign pu_b_wr = wr_en && (wr_addr == PU_B_ADDR);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        shadow_o[ch] <= '0;
      end else if (wr_en && (wr_addr == ADDR_W'(ch))) begin
        shadow_o[ch] <= wr_data;
      end
    end

    if (ch < PU_SPLIT) begin : g_pu_a
      always_ff @(posedge clk) begin
        if (rst) begin
          pullup_o[ch] <= 1'b0;
        end else if (pu_a_wr) begin
          pullup_o[ch] <= wr_data[PU_A_LSB + ch];
        end
      end
    end else begin : g_pu_b
      always_ff @(posedge clk) begin
        if (rst) begin
          pullup_o[ch] <= 1'b0;
        end else if (pu_b_wr) begin
          pullup_o[ch] <= wr_data[ch - PU_SPLIT];
        end
      end
    end
  end

endmodule

// File: rtl/pwm_od_channel.sv
module pwm_od_channel
  import pwm_od_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrap_i,
  input  logic [DATA_W-1:0] shadow_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] active_o,
  output logic              drv_low_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= '0;
    end else if (wrap_i) begin
      active_o <= shadow_i;
    end
  end

  assign drv_low_o = in_low_phase(active_o, cnt_i);

endmodule

// File: rtl/pwm_od_multi.sv
module pwm_od_multi
  import pwm_od_pkg::*;
#(
  parameter  int unsigned NUM_CH   = 7,
  parameter  int unsigned PRESCALE = 16,
  parameter  int unsigned PU_SPLIT = 3,
  parameter  int unsigned PU_A_LSB = 5,
  localparam int unsigned ADDR_W   = $clog2(NUM_CH + 2)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CH-1:0] drv_low_o,
  output logic [NUM_CH-1:0] pullup_en_o
);

  // Named internal events, also observed by the bound checker.
  logic                          tb_tick;
  logic                          tb_wrap;
  logic [DATA_W-1:0]             tb_cnt;
  logic [NUM_CH-1:0][DATA_W-1:0] duty_shadow;
  logic [NUM_CH-1:0][DATA_W-1:0] duty_active;

  pwm_od_timebase #(.PRESCALE(PRESCALE)) u_timebase (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tb_tick),
    .wrap_o (tb_wrap),
    .cnt_o  (tb_cnt)
  );

  pwm_od_regs #(
    .NUM_CH   (NUM_CH),
    .PU_SPLIT (PU_SPLIT),
    .PU_A_LSB (PU_A_LSB),
    .ADDR_W   (ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .shadow_o (duty_shadow),
    .pullup_o (pullup_en_o)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    pwm_od_channel u_chan (
      .clk       (clk),
      .rst       (rst),
      .wrap_i    (tb_wrap),
      .shadow_i  (duty_shadow[ch]),
      .cnt_i     (tb_cnt),
      .active_o  (duty_active[ch]),
      .drv_low_o (drv_low_o[ch])
    );
  end

endmodule

// File: rtl/pwm_od_multi_chk.sv
module pwm_od_multi_chk
  import pwm_od_pkg::*;
#(
  parameter int unsigned NUM_CH   = 7,
  parameter int unsigned PRESCALE = 16,
  parameter int unsigned PU_SPLIT = 3,
  parameter int unsigned ADDR_W   = 4
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          wr_en,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [PU_SPLIT-1:0]           pu_a_bits,
  input logic [NUM_CH-PU_SPLIT-1:0]    pu_b_bits,
  input logic                          tick,
  input logic                          wrap,
  input logic [DATA_W-1:0]             cnt,
  input logic [NUM_CH-1:0][DATA_W-1:0] active,
  input logic [NUM_CH-1:0]             drv_low_o,
  input logic [NUM_CH-1:0]             pullup_en_o
);

  localparam logic [ADDR_W-1:0] PU_A_ADDR = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] PU_B_ADDR = ADDR_W'(NUM_CH + 1);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (drv_low_o == '0) && (pullup_en_o == '0));

  assert_cnt_steps_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    tick |=> cnt == DATA_W'($past(cnt) + 1'b1));

  assert_cnt_holds_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt));

  if (PRESCALE > 1) begin : g_spacing
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);
  end

  assert_duty_only_at_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(active));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_zero
    assert_zero_never_low_R3: assert property (@(posedge clk) disable iff (rst)
      (active[g] == '0) |-> !drv_low_o[g]);
  end

  assert_pullup_a_load_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == PU_A_ADDR) |=> pullup_en_o[PU_SPLIT-1:0] == $past(pu_a_bits));

  assert_pullup_b_load_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == PU_B_ADDR) |=> pullup_en_o[NUM_CH-1:PU_SPLIT] == $past(pu_b_bits));

  assert_pullup_stable_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (wr_addr == PU_A_ADDR || wr_addr == PU_B_ADDR)) |=> $stable(pullup_en_o));

endmodule

bind pwm_od_multi pwm_od_multi_chk #(
  .NUM_CH   (NUM_CH),
  .PRESCALE (PRESCALE),
  .PU_SPLIT (PU_SPLIT),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .pu_a_bits   (wr_data[PU_A_LSB +: PU_SPLIT]),
  .pu_b_bits   (wr_data[NUM_CH-PU_SPLIT-1:0]),
  .tick        (tb_tick),
  .wrap        (tb_wrap),
  .cnt         (tb_cnt),
  .active      (duty_active),
  .drv_low_o   (drv_low_o),
  .pullup_en_o (pullup_en_o)
);

// File: tb/tb_pwm_od_multi.sv
module tb_pwm_od_multi;

  localparam int NCH = 7;
  localparam int PS  = 2;
  localparam int CYC = 256 * PS;
  localparam int NV  = 8;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'h01, 8'h02, 8'h10,
                                      8'h7F, 8'h80, 8'hFE, 8'hFF};

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [3:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic [NCH-1:0] drv_low;
  logic [NCH-1:0] pu;

  int unsigned k;
  int checks = 0;
  int errors = 0;

  pwm_od_multi #(.NUM_CH(NCH), .PRESCALE(PS)) dut (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .drv_low_o   (drv_low),
    .pullup_en_o (pu)
  );

  always #10 clk = ~clk;

  // Clock edges since reset release; cycle starts at multiples of CYC.
  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Low clocks per cycle: nothing for 0, two ticks for 1, one more tick per step after.
  function automatic int exp_low_clocks(input logic [7:0] d);
    if (d == 8'h00) return 0;
    return (2 + (int'(d) - 1)) * PS;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic to_boundary();
    do @(negedge clk); while ((k % CYC) != 0);
  endtask

  task automatic measure(input logic [7:0] d [NCH], input string tag);
    int lows [NCH];
    for (int ch = 0; ch < NCH; ch++) begin
      lows[ch] = 0;
      chk({tag, " start-low R4"}, int'(drv_low[ch]), int'(d[ch] != 8'h00));
    end
    for (int j = 0; j < CYC; j++) begin
      for (int ch = 0; ch < NCH; ch++) lows[ch] += int'(drv_low[ch]);
      @(negedge clk);
    end
    for (int ch = 0; ch < NCH; ch++)
      chk({tag, " low-clocks"}, lows[ch], exp_low_clocks(d[ch]));
  endtask

  initial begin
    #(200000 * 20);
    checks++; errors++;
    $display("FAIL watchdog R2 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] dv [NCH];

    repeat (3) @(negedge clk);
    chk("R1 reset drv_low", int'(drv_low), 0);
    chk("R1 reset pullup", int'(pu), 0);
    rst = 1'b0;

    // Vector table: each channel gets a different duty (R3 R4 R5 R10).
    for (int i = 0; i < NV; i++) begin
      to_boundary();
      for (int ch = 0; ch < NCH; ch++) begin
        dv[ch] = VEC[(i + ch) % NV];
        wr(4'(ch), dv[ch]);
      end
      to_boundary();
      measure(dv, "R3/R4/R5/R10 table");
    end

    // R2: duty 0x7F releases exactly 128 ticks into the cycle.
    wr(4'd0, 8'h7F);
    to_boundary();
    to_boundary();
    repeat (128 * PS - 1) @(negedge clk);
    chk("R2 last low clock", int'(drv_low[0]), 1);
    @(negedge clk);
    chk("R2 first high clock", int'(drv_low[0]), 0);

    // R6: new duty waits for the cycle boundary.
    wr(4'd0, 8'h10);
    to_boundary();
    to_boundary();
    wr(4'd0, 8'h00);
    chk("R6 old duty still low", int'(drv_low[0]), 1);
    repeat (16 * PS) @(negedge clk);
    chk("R6 old duty released", int'(drv_low[0]), 0);
    to_boundary();
    chk("R6 new duty in force", int'(drv_low[0]), 0);

    // R7 / R8 pull-up mapping; unused bits ignored.
    wr(4'd7, 8'b1010_0000);
    chk("R7 pullup bits 7:5", int'(pu), 7'b0000101);
    wr(4'd7, 8'h1F);
    chk("R7 low bits ignored", int'(pu), 0);
    wr(4'd8, 8'hF5);
    chk("R8 pullup bits 3:0", int'(pu), 7'b0101000);
    wr(4'd7, 8'hE0);
    chk("R7 R8 both regs", int'(pu), 7'b0101111);

    // R9: disabled and out-of-range writes change nothing.
    for (int ch = 0; ch < NCH; ch++) begin
      dv[ch] = 8'h00;
      wr(4'(ch), 8'h00);
    end
    wr(4'd9, 8'hFF);
    wr(4'd15, 8'h00);
    @(negedge clk);
    wr_addr = 4'd0; wr_data = 8'hFF;
    @(negedge clk);
    wr_addr = 4'd7; wr_data = 8'h00;
    @(negedge clk);
    chk("R9 pullup unchanged", int'(pu), 7'b0101111);
    to_boundary();
    to_boundary();
    measure(dv, "R9 no duty change");

    // R1 mid-run reset.
    wr(4'd3, 8'hFF);
    to_boundary();
    to_boundary();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 midrun drv_low", int'(drv_low), 0);
    chk("R1 midrun pullup", int'(pu), 0);
    rst = 1'b0;
    to_boundary();
    to_boundary();
    measure(dv, "R1 duty cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule